// File: doc/BRIEF.md
# Thermal Limit Alert with Consecutive-Fault Filter

This block watches the stream of signed temperature results produced by a sensor's converter. Each new result is compared against a high and a low limit held in the block, and an alert line is driven once a programmable number of back-to-back out-of-range readings has been seen. A single noisy reading therefore cannot raise or drop the alert.

Two alert behaviours are available. In comparator mode the alert follows a hysteresis loop: it is raised by a run of high readings and dropped by a run of low readings. In interrupt mode the alert latches until software clears it, and after each clear the block waits for the opposite threshold crossing. The block also provides a status bit with comparator behaviour, a flag giving the cause of the latest interrupt-mode alert, and the formatted temperature word. Configuration writes, limit writes and a bus-wide general-call reset come from the surrounding register interface.

Top module: `tlim_alert`

## Requirements
- R1: The 2-bit queue field sets the number of consecutive qualifying readings needed: 00 needs 1, 01 needs 2, 10 needs 4, 11 needs 6.
- R2: A reading counts as high when it is greater than or equal to the high limit, and as low only when it is strictly less than the low limit. Comparisons are signed two's complement at 0.0625 °C per LSB.
- R3: Any reading that does not meet the condition currently being watched resets the consecutive count to zero.
- R4: In comparator mode the alert becomes active after the required run of high readings and returns idle only after the required run of low readings. Readings between the limits change nothing.
- R5: In interrupt mode (mode bit 1) the alert becomes active after the required run of high readings and stays active until a register-read event, an alert-response event or a shutdown-entry event.
- R6: After an interrupt-mode clear, the next activation needs the required run of low readings, and the one after that needs a run of high readings again. The cause output is 0 for an activation by the high limit and 1 for one by the low limit.
- R7: With polarity 0 the alert pin is low when active and high when idle. With polarity 1 it is high when active.
- R8: The status bit always follows the comparator state, whatever the mode bit. With polarity 0 it reads 1 when idle and 0 when active, and polarity 1 inverts it.
- R9: After reset the high limit word is 0x5000 (+80 °C), the low limit word is 0x4B00 (+75 °C), the configuration is comparator mode, polarity 0, queue 00 and normal width, and the temperature word reads 0x0000.
- R10: In normal width a limit is bits 15:4 of its word and the temperature word is the 12-bit value left-justified, with bits 3:0 zero. With the extended bit set, a limit is bits 15:3 and the temperature word is the 13-bit value in bits 15:3, with bit 0 set to 1.
- R11: A general-call reset returns the limits and configuration to their reset values, clears the alert and all counts, and so leaves the block in comparator mode.
- R12: When an interrupt-mode activation and a clear event fall in the same cycle, the activation wins and the alert ends active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gc_rst | input | 1 | General-call reset pulse |
| cfg_we | input | 1 | Load the configuration fields below |
| cfg_ext | input | 1 | Extended 13-bit width |
| cfg_int_mode | input | 1 | 1 selects interrupt mode, 0 comparator mode |
| cfg_pol | input | 1 | Alert polarity, 1 means active high |
| cfg_queue | input | 2 | Consecutive-reading code |
| hi_we | input | 1 | Write the high limit word |
| lo_we | input | 1 | Write the low limit word |
| lim_wdata | input | 16 | Limit word to write |
| sample_vld | input | 1 | A new temperature result is present |
| sample_temp | input | 13 | Signed result; only bits 11:0 are used in normal width |
| rd_evt | input | 1 | A register read took place |
| ares_evt | input | 1 | An alert response succeeded |
| shdn_evt | input | 1 | Shutdown was entered |
| alert_o | output | 1 | Alert pin level |
| status_o | output | 1 | Readable comparator status bit |
| cause_low_o | output | 1 | Cause of the last interrupt activation (1 = low) |
| temp_word_o | output | 16 | Formatted latest temperature word |
| hi_limit_o | output | 16 | Current high limit word |
| lo_limit_o | output | 16 | Current low limit word |

## Verification
The two functions that can fall in the same cycle are the interrupt-mode activation at the end of a qualifying run and a clear event, either a register read or an alert response. The bench first clears a pending alert so that the interrupt path is armed for the high limit. It then drives a qualifying high reading and a read event on the same clock edge. The run passes only if the alert pin then shows active, as R12 requires. The same sequence also shows that the comparator status bit, which clear events never touch, stays consistent with the readings.

// File: rtl/tlim_pkg.sv
package tlim_pkg;

  localparam int QW = 3;

  typedef struct packed {
    logic       ext;
    logic       int_mode;
    logic       pol;
    logic [1:0] queue;
  } tlim_cfg_t;

  localparam tlim_cfg_t CFG_RST = '{ext: 1'b0, int_mode: 1'b0, pol: 1'b0, queue: 2'b00};

  function automatic logic [QW-1:0] queue_need(input logic [1:0] code);
    case (code)
      2'b00:   queue_need = QW'(1);
      2'b01:   queue_need = QW'(2);
      2'b10:   queue_need = QW'(4);
      default: queue_need = QW'(6);
    endcase
  endfunction

endpackage

// File: rtl/tlim_regs.sv
module tlim_regs
  import tlim_pkg::*;
#(
  parameter int WW = 16,
  parameter logic [WW-1:0] HI_RST = 16'h5000,
  parameter logic [WW-1:0] LO_RST = 16'h4B00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gc_rst,
  input  logic          cfg_we,
  input  tlim_cfg_t     cfg_d,
  input  logic          hi_we,
  input  logic          lo_we,
  input  logic [WW-1:0] wdata,
  output tlim_cfg_t     cfg_q,
  output logic [WW-1:0] hi_q,
  output logic [WW-1:0] lo_q
);

  always_ff @(posedge clk) begin
    if (rst || gc_rst) begin
      cfg_q <= CFG_RST;
      hi_q  <= HI_RST;
      lo_q  <= LO_RST;
    end else begin
      if (cfg_we) cfg_q <= cfg_d;
      if (hi_we)  hi_q  <= wdata;
      if (lo_we)  lo_q  <= wdata;
    end
  end

  // R11: a general-call reset restores the limits and comparator mode
  assert_gc_default_R11: assert property (@(posedge clk) disable iff (rst)
    gc_rst |=> (hi_q == HI_RST && lo_q == LO_RST && !cfg_q.int_mode));

endmodule

// File: rtl/tlim_compare.sv
module tlim_compare #(
  parameter int TW = 13,
  parameter int WW = 16
) (
  input  logic          ext,
  input  logic [TW-1:0] temp,
  input  logic [WW-1:0] hi_word,
  input  logic [WW-1:0] lo_word,
  output logic          hi_hit,
  output logic          lo_hit,
  output logic [WW-1:0] word
);

  localparam int NW   = TW - 1;
  localparam int EPAD = WW - TW;
  localparam int NPAD = WW - NW;

  logic signed [TW-1:0] t_v, hi_v, lo_v;

  always_comb begin
    if (ext) begin
      t_v  = temp;
      hi_v = hi_word[WW-1:EPAD];
      lo_v = lo_word[WW-1:EPAD];
      word = {temp, {(EPAD-1){1'b0}}, 1'b1};
    end else begin
      t_v  = {temp[NW-1], temp[NW-1:0]};
      hi_v = {hi_word[WW-1], hi_word[WW-1:NPAD]};
      lo_v = {lo_word[WW-1], lo_word[WW-1:NPAD]};
      word = {temp[NW-1:0], {NPAD{1'b0}}};
    end
    hi_hit = (t_v >= hi_v);
    lo_hit = (t_v < lo_v);
  end

endmodule

// File: rtl/tlim_fqueue.sv
module tlim_fqueue #(
  parameter int QW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          step,
  input  logic          cond,
  input  logic [QW-1:0] need,
  output logic          reached
);

  logic [QW-1:0] cnt;
  logic [QW-1:0] nxt;

  assign nxt     = cnt + QW'(1);
  assign reached = step && cond && (nxt >= need);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt <= '0;
    end else if (step) begin
      if (cond && !reached) cnt <= nxt;
      else                  cnt <= '0;
    end
  end

  // R1: the count never reaches the deepest queue setting
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt < QW'(6));

  // R3: a non-qualifying reading empties the count
  assert_break_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !cond) |=> (cnt == '0));

endmodule

// File: rtl/tlim_alert.sv
module tlim_alert
  import tlim_pkg::*;
#(
  parameter int TW = 13,
  parameter int WW = 16,
  parameter logic [WW-1:0] HI_RST = 16'h5000,
  parameter logic [WW-1:0] LO_RST = 16'h4B00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gc_rst,
  input  logic          cfg_we,
  input  logic          cfg_ext,
  input  logic          cfg_int_mode,
  input  logic          cfg_pol,
  input  logic [1:0]    cfg_queue,
  input  logic          hi_we,
  input  logic          lo_we,
  input  logic [WW-1:0] lim_wdata,
  input  logic          sample_vld,
  input  logic [TW-1:0] sample_temp,
  input  logic          rd_evt,
  input  logic          ares_evt,
  input  logic          shdn_evt,
  output logic          alert_o,
  output logic          status_o,
  output logic          cause_low_o,
  output logic [WW-1:0] temp_word_o,
  output logic [WW-1:0] hi_limit_o,
  output logic [WW-1:0] lo_limit_o
);

  tlim_cfg_t     cfg_d, cfg_q;
  logic [WW-1:0] hi_q, lo_q, word_c;
  logic          hi_hit, lo_hit;
  logic [QW-1:0] need;

  assign cfg_d = '{ext: cfg_ext, int_mode: cfg_int_mode, pol: cfg_pol, queue: cfg_queue};

  tlim_regs #(.WW(WW), .HI_RST(HI_RST), .LO_RST(LO_RST)) u_regs (
    .clk(clk), .rst(rst), .gc_rst(gc_rst),
    .cfg_we(cfg_we), .cfg_d(cfg_d),
    .hi_we(hi_we), .lo_we(lo_we), .wdata(lim_wdata),
    .cfg_q(cfg_q), .hi_q(hi_q), .lo_q(lo_q)
  );

  tlim_compare #(.TW(TW), .WW(WW)) u_cmp (
    .ext(cfg_q.ext), .temp(sample_temp),
    .hi_word(hi_q), .lo_word(lo_q),
    .hi_hit(hi_hit), .lo_hit(lo_hit), .word(word_c)
  );

  assign need = queue_need(cfg_q.queue);

  // comparator path: hysteresis state
  logic cmp_act, cmp_cond, cmp_reach;
  assign cmp_cond = cmp_act ? lo_hit : hi_hit;

  tlim_fqueue #(.QW(QW)) u_q_cmp (
    .clk(clk), .rst(rst), .hold(gc_rst),
    .step(sample_vld), .cond(cmp_cond), .need(need), .reached(cmp_reach)
  );

  always_ff @(posedge clk) begin
    if (rst || gc_rst)  cmp_act <= 1'b0;
    else if (cmp_reach) cmp_act <= ~cmp_act;
  end

  // interrupt path: latched alert, re-armed for the opposite crossing
  logic int_act, watch_low, int_cause, int_hold, int_cond, int_reach, clr;
  assign int_hold = gc_rst || !cfg_q.int_mode;
  assign int_cond = watch_low ? lo_hit : hi_hit;
  assign clr      = rd_evt || ares_evt || shdn_evt;

  tlim_fqueue #(.QW(QW)) u_q_int (
    .clk(clk), .rst(rst), .hold(int_hold),
    .step(sample_vld && !int_act), .cond(int_cond), .need(need), .reached(int_reach)
  );

  always_ff @(posedge clk) begin
    if (rst || int_hold) begin
      int_act   <= 1'b0;
      watch_low <= 1'b0;
      int_cause <= 1'b0;
    end else if (int_reach) begin
      int_act   <= 1'b1;
      int_cause <= watch_low;
      watch_low <= ~watch_low;
    end else if (clr) begin
      int_act   <= 1'b0;
    end
  end

  // registered outputs
  logic active;
  assign active = cfg_q.int_mode ? int_act : cmp_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      alert_o     <= 1'b1;
      status_o    <= 1'b1;
      cause_low_o <= 1'b0;
      temp_word_o <= '0;
    end else begin
      alert_o     <= cfg_q.pol ? active  : ~active;
      status_o    <= cfg_q.pol ? cmp_act : ~cmp_act;
      cause_low_o <= int_cause;
      if (gc_rst)          temp_word_o <= '0;
      else if (sample_vld) temp_word_o <= word_c;
    end
  end

  assign hi_limit_o = hi_q;
  assign lo_limit_o = lo_q;

  // R2: both conditions at once only when the limits are inverted
  assert_limit_order_R2: assert property (@(posedge clk) disable iff (rst)
    (hi_hit && lo_hit) |-> (cfg_q.ext ? ($signed(hi_q[WW-1:WW-TW]) < $signed(lo_q[WW-1:WW-TW]))
                                      : ($signed(hi_q[WW-1:WW-TW+1]) < $signed(lo_q[WW-1:WW-TW+1]))));

  // R4: comparator state moves only on a reading or a general-call reset
  assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!sample_vld && !gc_rst) |=> $stable(cmp_act));

  // R5: a clear with no reading drops the latched alert
  assert_int_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && !sample_vld && !gc_rst) |=> !int_act);

  // R12: activation beats a clear in the same cycle
  assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
    (int_reach && clr && !gc_rst && !cfg_we) |=> int_act);

endmodule

// File: tb/tlim_alert_tb.sv
module tlim_alert_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gc_rst = 0, cfg_we = 0, cfg_ext = 0, cfg_int_mode = 0, cfg_pol = 0;
  logic [1:0]  cfg_queue = 0;
  logic        hi_we = 0, lo_we = 0;
  logic [15:0] lim_wdata = 0;
  logic        sample_vld = 0;
  logic [12:0] sample_temp = 0;
  logic        rd_evt = 0, ares_evt = 0, shdn_evt = 0;
  logic        alert_o, status_o, cause_low_o;
  logic [15:0] temp_word_o, hi_limit_o, lo_limit_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlim_alert u_dut (
    .clk(clk), .rst(rst), .gc_rst(gc_rst), .cfg_we(cfg_we), .cfg_ext(cfg_ext),
    .cfg_int_mode(cfg_int_mode), .cfg_pol(cfg_pol), .cfg_queue(cfg_queue),
    .hi_we(hi_we), .lo_we(lo_we), .lim_wdata(lim_wdata),
    .sample_vld(sample_vld), .sample_temp(sample_temp),
    .rd_evt(rd_evt), .ares_evt(ares_evt), .shdn_evt(shdn_evt),
    .alert_o(alert_o), .status_o(status_o), .cause_low_o(cause_low_o),
    .temp_word_o(temp_word_o), .hi_limit_o(hi_limit_o), .lo_limit_o(lo_limit_o)
  );

  // {temp, expected status, expected alert} in comparator mode, queue 00, polarity 0
  localparam logic [14:0] VEC [8] = '{
    {13'd1000,  1'b1, 1'b1},
    {13'd1280,  1'b0, 1'b0},
    {13'd1279,  1'b0, 1'b0},
    {13'd1200,  1'b0, 1'b0},
    {13'd1199,  1'b1, 1'b1},
    {13'h1E70,  1'b1, 1'b1},
    {13'd1279,  1'b1, 1'b1},
    {13'd2000,  1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic samp(input logic [12:0] t);
    @(negedge clk); sample_vld = 1; sample_temp = t;
    @(negedge clk); sample_vld = 0;
    settle();
  endtask

  task automatic set_cfg(input logic e, input logic im, input logic p, input logic [1:0] q);
    @(negedge clk); cfg_we = 1; cfg_ext = e; cfg_int_mode = im; cfg_pol = p; cfg_queue = q;
    @(negedge clk); cfg_we = 0;
    settle();
  endtask

  task automatic pulse_gc();
    @(negedge clk); gc_rst = 1;
    @(negedge clk); gc_rst = 0;
    settle();
  endtask

  task automatic pulse_clr(input int which);
    @(negedge clk);
    if (which == 0) rd_evt = 1; else if (which == 1) ares_evt = 1; else shdn_evt = 1;
    @(negedge clk); rd_evt = 0; ares_evt = 0; shdn_evt = 0;
    settle();
  endtask

  task automatic wr_lim(input logic hi, input logic [15:0] d);
    @(negedge clk); lim_wdata = d; hi_we = hi; lo_we = !hi;
    @(negedge clk); hi_we = 0; lo_we = 0;
    settle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    settle();
    // reset state
    chk("R9 hi limit", 32'(hi_limit_o), 32'h5000);
    chk("R9 lo limit", 32'(lo_limit_o), 32'h4B00);
    chk("R9 temp word", 32'(temp_word_o), 32'h0);
    chk("R7 idle alert", 32'(alert_o), 32'h1);
    chk("R8 idle status", 32'(status_o), 32'h1);

    // vector table, comparator mode: R2 R4 R7 R8
    for (int i = 0; i < 8; i++) begin
      samp(VEC[i][14:2]);
      chk("R2/R4 vec status", 32'(status_o), 32'(VEC[i][1]));
      chk("R4/R7 vec alert", 32'(alert_o), 32'(VEC[i][0]));
    end
    samp(13'd1000);
    chk("R10 normal word", 32'(temp_word_o), 32'h3E80);
    pulse_gc();
    chk("R11 alert idle after gc", 32'(alert_o), 32'h1);

    // fault queue depth 4 with a break: R1 R3
    set_cfg(0, 0, 0, 2'b10);
    repeat (3) samp(13'd1300);
    chk("R1 three of four", 32'(alert_o), 32'h1);
    samp(13'd1000);
    repeat (3) samp(13'd1300);
    chk("R3 run broken", 32'(alert_o), 32'h1);
    samp(13'd1300);
    chk("R1 fourth high", 32'(alert_o), 32'h0);
    set_cfg(0, 0, 0, 2'b11);
    repeat (5) samp(13'd1000);
    chk("R1 five of six", 32'(alert_o), 32'h0);
    samp(13'd1250);
    repeat (5) samp(13'd1000);
    chk("R3 low run broken", 32'(alert_o), 32'h0);
    samp(13'd1000);
    chk("R1 sixth low", 32'(alert_o), 32'h1);
    set_cfg(0, 0, 0, 2'b01);
    samp(13'd1300);
    chk("R1 one of two", 32'(alert_o), 32'h1);
    samp(13'd1300);
    chk("R1 two of two", 32'(alert_o), 32'h0);
    pulse_gc();

    // interrupt mode: R5 R6 R8
    set_cfg(0, 1, 0, 2'b00);
    samp(13'd1300);
    chk("R5 int active", 32'(alert_o), 32'h0);
    chk("R6 cause high", 32'(cause_low_o), 32'h0);
    samp(13'd1300);
    chk("R5 stays latched", 32'(alert_o), 32'h0);
    pulse_clr(0);
    chk("R5 read clears", 32'(alert_o), 32'h1);
    chk("R8 status ignores clear", 32'(status_o), 32'h0);
    samp(13'd1300);
    chk("R6 rearmed low", 32'(alert_o), 32'h1);
    samp(13'd1000);
    chk("R6 low activation", 32'(alert_o), 32'h0);
    chk("R6 cause low", 32'(cause_low_o), 32'h1);
    chk("R8 status released", 32'(status_o), 32'h1);
    pulse_clr(1);
    chk("R5 alert response clears", 32'(alert_o), 32'h1);
    samp(13'd1300);
    chk("R6 back to high", 32'(alert_o), 32'h0);
    chk("R6 cause high again", 32'(cause_low_o), 32'h0);
    pulse_clr(2);
    chk("R5 shutdown clears", 32'(alert_o), 32'h1);

    // polarity 1: R7 R8
    set_cfg(0, 1, 1, 2'b00);
    chk("R7 pol1 idle", 32'(alert_o), 32'h0);
    samp(13'd1000);
    chk("R7 pol1 active", 32'(alert_o), 32'h1);
    chk("R8 pol1 status idle", 32'(status_o), 32'h0);
    pulse_clr(0);
    chk("R7 pol1 cleared", 32'(alert_o), 32'h0);
    // same-cycle activation and clear: R12
    @(negedge clk); sample_vld = 1; sample_temp = 13'd1300; rd_evt = 1;
    @(negedge clk); sample_vld = 0; rd_evt = 0;
    settle();
    chk("R12 set wins over clear", 32'(alert_o), 32'h1);
    chk("R8 pol1 status active", 32'(status_o), 32'h1);

    // general-call reset: R11
    wr_lim(1, 16'h6000);
    chk("R11 limit written", 32'(hi_limit_o), 32'h6000);
    pulse_gc();
    chk("R11 limit restored", 32'(hi_limit_o), 32'h5000);
    chk("R11 alert idle", 32'(alert_o), 32'h1);
    chk("R11 temp word cleared", 32'(temp_word_o), 32'h0);
    samp(13'd1300);
    pulse_clr(0);
    chk("R11 comparator ignores read", 32'(alert_o), 32'h0);
    pulse_gc();

    // extended width: R10
    set_cfg(1, 0, 0, 2'b00);
    wr_lim(1, 16'h4B00);
    wr_lim(0, 16'h3E80);
    samp(13'd2399);
    chk("R10 below ext limit", 32'(alert_o), 32'h1);
    chk("R10 ext word", 32'(temp_word_o), 32'h4AF9);
    samp(13'd2400);
    chk("R10 at ext limit", 32'(alert_o), 32'h0);
    chk("R10 ext word flag", 32'(temp_word_o), 32'h4B01);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule